// File: doc/BRIEF.md
# I2C General-Call Software Reset Detector

This block sits behind an I2C target's bit-level front end. It watches the decoded bus events: START, repeated START and STOP, each a one-cycle strobe. It also watches each received byte, which arrives with a one-cycle valid strobe. From these it recognises the one byte sequence that asks every device on the bus to return to its power-up state. That sequence is a START, then the general-call write byte 00h, then the command byte 06h, then a STOP.

While the sequence is in progress, the block tells the front end which bytes to acknowledge. It raises `ack_req` during the acknowledge window only for a byte that the sequence accepts. When the STOP arrives right after an acknowledged command byte, the block issues a single-cycle reset pulse. The surrounding device uses that pulse to reload its power-up values, for example setting every port latch bit high. Every other order of events abandons the sequence without a reset: a wrong byte, an extra byte, or a repeated START where the STOP should be.

Top module: `gc_swreset_det`

## Requirements
- R1: While `rst_n` is low and after it is released, `sw_reset_pulse` is 0 and `ack_req` stays 0 even when `ack_window` is high.
- R2: After a START, a received byte equal to 00h (general-call address, write) makes `ack_req` high for the duration of the following `ack_window`.
- R3: After a START, a received byte of 01h (general call with the read bit) is not acknowledged. It does not arm the sequence: a following 06h is also not acknowledged, and a STOP gives no pulse.
- R4: After an acknowledged 00h, a byte of 06h is acknowledged. Any other value is not acknowledged, and the sequence is dropped, so a following STOP gives no pulse.
- R5: Any byte received after an acknowledged 06h is not acknowledged, and a STOP after it gives no pulse.
- R6: A STOP that comes directly after an acknowledged 06h sets `sw_reset_pulse` high for exactly one clock cycle. That cycle is the one after the clock edge at which the STOP strobe is sampled.
- R7: A repeated START where that STOP should be cancels the sequence. No pulse is produced, and a byte that follows is not acknowledged.
- R8: `ack_req` is high only while `ack_window` is high. Any START, repeated START or STOP discards a pending acknowledge decision.
- R9: When a bus event and a byte strobe fall in the same cycle, the event takes effect and the byte is discarded.
- R10: A START in any state begins a fresh sequence, so an earlier abandoned sequence does not stop a later complete one from resetting.
- R11: A byte that arrives with no START since the last STOP or repeated START is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle strobe: START detected |
| bus_rstart | input | 1 | One-cycle strobe: repeated START detected |
| bus_stop | input | 1 | One-cycle strobe: STOP detected |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a complete byte |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| ack_window | input | 1 | High during the acknowledge bit slot |
| ack_req | output | 1 | Request to drive ACK in the current slot |
| sw_reset_pulse | output | 1 | One-cycle software reset pulse |

## Verification
A bus-event strobe and a byte-complete strobe can land in the same clock cycle, and the block must decide which of the two wins. The bench provokes this twice. In the first case, a STOP is strobed together with the command byte 06h while the general call is acknowledged. In the second, a START is strobed together with 00h from idle. The result is judged at the ports. The first case must give no reset pulse and no acknowledge in the next window. In the second, the following 06h must be refused, which shows that the 00h was dropped while the START still took effect.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ADDR  = 3'd1,
    S_GC_OK = 3'd2,
    S_ARMED = 3'd3,
    S_ABORT = 3'd4
  } gcsr_state_e;

  // exact byte comparison, kept here so the bench can restate it
  function automatic logic byte_is(input logic [BYTE_W-1:0] b,
                                   input logic [BYTE_W-1:0] ref_v);
    return (b == ref_v);
  endfunction

  // general-call write: address field zero and direction bit zero
  function automatic logic is_gc_write(input logic [BYTE_W-1:0] b,
                                       input logic [BYTE_W-1:0] gc_v);
    return byte_is(b, gc_v) && (b[0] == 1'b0);
  endfunction

endpackage

// File: rtl/gcsr_classify.sv
module gcsr_classify
  import gcsr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] GC_BYTE  = 8'h00,
  parameter logic [BYTE_W-1:0] CMD_BYTE = 8'h06
) (
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              hit_gc,
  output logic              hit_cmd
);
  always_comb begin
    hit_gc  = is_gc_write(rx_byte, GC_BYTE);
    hit_cmd = byte_is(rx_byte, CMD_BYTE);
  end
endmodule

// File: rtl/gcsr_fsm.sv
module gcsr_fsm
  import gcsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_rstart,
  input  logic        ev_stop,
  input  logic        rx_valid,
  input  logic        hit_gc,
  input  logic        hit_cmd,
  output gcsr_state_e state_q,
  output logic        byte_ack,
  output logic        fire
);
  gcsr_state_e state_d;
  logic        any_evt;
  logic        take_byte;

  assign any_evt   = ev_start | ev_rstart | ev_stop;
  assign take_byte = rx_valid & ~any_evt;

  always_comb begin
    state_d  = state_q;
    byte_ack = 1'b0;
    if (ev_start) begin
      state_d = S_ADDR;
    end else if (ev_rstart || ev_stop) begin
      state_d = S_IDLE;
    end else if (take_byte) begin
      unique case (state_q)
        S_ADDR: begin
          state_d  = hit_gc ? S_GC_OK : S_ABORT;
          byte_ack = hit_gc;
        end
        S_GC_OK: begin
          state_d  = hit_cmd ? S_ARMED : S_ABORT;
          byte_ack = hit_cmd;
        end
        S_ARMED: state_d = S_ABORT;
        S_ABORT: state_d = S_ABORT;
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign fire = (state_q == S_ARMED) & ev_stop & ~ev_start & ~ev_rstart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  AST_ARMED_VIA_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ARMED) |-> ($past(state_q) == S_GC_OK || $past(state_q) == S_ARMED)); // R4
  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_ABORT && !$past(any_evt)) |-> (state_q == S_ABORT)); // R5
endmodule

// File: rtl/gcsr_ackgen.sv
module gcsr_ackgen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_evt,
  input  logic rx_valid,
  input  logic byte_ack,
  input  logic ack_window,
  output logic ack_req
);
  logic ack_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ack_pend_q <= 1'b0;
    else if (any_evt)  ack_pend_q <= 1'b0;
    else if (rx_valid) ack_pend_q <= byte_ack;
  end

  assign ack_req = ack_window & ack_pend_q;

  AST_EVT_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> !ack_req); // R8
endmodule

// File: rtl/gcsr_pulse.sv
module gcsr_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R6
endmodule

// File: rtl/gc_swreset_det.sv
module gc_swreset_det
  import gcsr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] GC_BYTE  = 8'h00,
  parameter logic [BYTE_W-1:0] CMD_BYTE = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_rstart,
  input  logic              bus_stop,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ack_window,
  output logic              ack_req,
  output logic              sw_reset_pulse
);
  logic        hit_gc, hit_cmd, byte_ack, fire, any_evt;
  gcsr_state_e state_q;

  assign any_evt = bus_start | bus_rstart | bus_stop;

  gcsr_classify #(.GC_BYTE(GC_BYTE), .CMD_BYTE(CMD_BYTE)) u_cls (
    .rx_byte (rx_byte),
    .hit_gc  (hit_gc),
    .hit_cmd (hit_cmd)
  );

  gcsr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (bus_start),
    .ev_rstart (bus_rstart),
    .ev_stop   (bus_stop),
    .rx_valid  (rx_valid),
    .hit_gc    (hit_gc),
    .hit_cmd   (hit_cmd),
    .state_q   (state_q),
    .byte_ack  (byte_ack),
    .fire      (fire)
  );

  gcsr_ackgen u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_evt    (any_evt),
    .rx_valid   (rx_valid),
    .byte_ack   (byte_ack),
    .ack_window (ack_window),
    .ack_req    (ack_req)
  );

  gcsr_pulse u_pls (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .pulse (sw_reset_pulse)
  );

  AST_PULSE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_pulse |-> $past(bus_stop)); // R6
  AST_RSTART_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rstart |=> !sw_reset_pulse); // R7
  AST_ACK_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (state_q == S_GC_OK || state_q == S_ARMED)); // R8
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !any_evt && state_q == S_IDLE) |=> !ack_req); // R11
endmodule

// File: tb/sim_gc_swreset_det.sv
`timescale 1ns/1ps
module sim_gc_swreset_det;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_rstart = 1'b0, bus_stop = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ack_window = 1'b0;
  logic       ack_req, sw_reset_pulse;
  int         n_chk = 0, n_bad = 0, n_pulse = 0;

  always #2 clk = ~clk;

  gc_swreset_det u0 (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rstart(bus_rstart),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ack_window(ack_window), .ack_req(ack_req), .sw_reset_pulse(sw_reset_pulse)
  );

  always @(negedge clk) if (sw_reset_pulse) n_pulse++;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // kind: 0 start, 1 repeated start, 2 stop
  task automatic bus_evt(input int kind);
    @(negedge clk);
    bus_start  = (kind == 0);
    bus_rstart = (kind == 1);
    bus_stop   = (kind == 2);
    @(negedge clk);
    bus_start = 1'b0; bus_rstart = 1'b0; bus_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(ack_req, 1'b0, {tag, " before window"});
    ack_window = 1'b1;
    #1 chk(ack_req, exp_ack, tag);
    @(negedge clk);
    #1 chk(ack_req, exp_ack, {tag, " held"});
    ack_window = 1'b0;
    #0.5 chk(ack_req, 1'b0, {tag, " after window"});
  endtask

  task automatic stop_expect(input logic exp_pulse, input string tag);
    int base;
    base = n_pulse;
    bus_evt(2);
    chk(sw_reset_pulse, exp_pulse, {tag, " pulse cycle"});
    @(negedge clk);
    chk(sw_reset_pulse, 1'b0, {tag, " pulse gone"});
    repeat (3) @(negedge clk);
    chk(n_pulse - base == (exp_pulse ? 1 : 0), 1'b1, {tag, " pulse count"});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    ack_window = 1'b1;
    #1 chk(ack_req, 1'b0, "R1 ack in reset");
    chk(sw_reset_pulse, 1'b0, "R1 pulse in reset");
    ack_window = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    ack_window = 1'b1;
    #1 chk(ack_req, 1'b0, "R1 ack after reset");
    chk(sw_reset_pulse, 1'b0, "R1 pulse after reset");
    ack_window = 1'b0;
  endtask

  task automatic t_full_sequence;
    bus_evt(0);
    send_byte(8'h00, 1'b1, "R2 gc write acked");
    send_byte(8'h06, 1'b1, "R4 cmd acked");
    stop_expect(1'b1, "R6 full sequence");
  endtask

  task automatic t_gc_read;
    bus_evt(0);
    send_byte(8'h01, 1'b0, "R3 gc read nacked");
    send_byte(8'h06, 1'b0, "R3 cmd after read nacked");
    stop_expect(1'b0, "R3 no reset");
  endtask

  task automatic t_bad_cmd;
    bus_evt(0);
    send_byte(8'h00, 1'b1, "R2 gc write acked");
    send_byte(8'h07, 1'b0, "R4 wrong cmd nacked");
    stop_expect(1'b0, "R4 no reset");
  endtask

  task automatic t_extra_byte;
    bus_evt(0);
    send_byte(8'h00, 1'b1, "R2 gc write acked");
    send_byte(8'h06, 1'b1, "R4 cmd acked");
    send_byte(8'h06, 1'b0, "R5 extra byte nacked");
    stop_expect(1'b0, "R5 no reset");
  endtask

  task automatic t_rstart_cancel;
    bus_evt(0);
    send_byte(8'h00, 1'b1, "R2 gc write acked");
    send_byte(8'h06, 1'b1, "R4 cmd acked");
    bus_evt(1);
    chk(sw_reset_pulse, 1'b0, "R7 no pulse on rstart");
    send_byte(8'h00, 1'b0, "R7 byte after rstart nacked");
    stop_expect(1'b0, "R7 no reset");
  endtask

  task automatic t_event_drops_ack;
    bus_evt(0);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h00;
    @(negedge clk);
    rx_valid = 1'b0;
    #1 chk(ack_req, 1'b0, "R8 no ack outside window");
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
    ack_window = 1'b1;
    #1 chk(ack_req, 1'b0, "R8 stop drops pending ack");
    @(negedge clk);
    ack_window = 1'b0;
  endtask

  task automatic t_collide;
    bus_evt(0);
    send_byte(8'h00, 1'b1, "R2 gc write acked");
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h06; bus_stop = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_stop = 1'b0;
    chk(sw_reset_pulse, 1'b0, "R9 stop with byte no pulse");
    ack_window = 1'b1;
    #1 chk(ack_req, 1'b0, "R9 colliding byte not acked");
    @(negedge clk);
    ack_window = 1'b0;
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h00; bus_start = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_start = 1'b0;
    send_byte(8'h06, 1'b0, "R9 byte with start discarded");
    stop_expect(1'b0, "R9 no reset");
  endtask

  task automatic t_restart_after_abort;
    bus_evt(0);
    send_byte(8'h05, 1'b0, "R10 foreign byte nacked");
    bus_evt(0);
    send_byte(8'h00, 1'b1, "R10 gc after new start acked");
    send_byte(8'h06, 1'b1, "R10 cmd acked");
    stop_expect(1'b1, "R10 reset after fresh start");
  endtask

  task automatic t_idle_byte;
    send_byte(8'h00, 1'b0, "R11 byte without start nacked");
    send_byte(8'h06, 1'b0, "R11 second idle byte nacked");
    stop_expect(1'b0, "R11 no reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_full_sequence();
    t_gc_read();
    t_bad_cmd();
    t_extra_byte();
    t_rstart_cancel();
    t_event_drops_ack();
    t_collide();
    t_restart_after_abort();
    t_idle_byte();
    chk(n_pulse == 2, 1'b1, "R6 total pulses");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule